// File: doc/BRIEF.md
# Debug Control Register

This block is an 8-bit control register that sits between a processor core and the link to an external debug host. The host writes it through a simple write strobe and byte. The core's instruction decoder pulses an input whenever it decodes the breakpoint opcode (00H). A status input reports whether flash read protection is active. From these inputs the block produces three outputs. The first stops the core from fetching instructions. The second is a one-cycle request to send an acknowledge byte to the host. The third is a core-reset output that resets the rest of the device but not this register.

Once the host has set the breakpoint-enable bit, a decoded breakpoint opcode halts the core by itself. When read protection is active, the host cannot release the halt by writing; only a power-on reset releases it. Writing the self-clearing reset bit runs a fixed-length device reset. The bit then drops by itself, and the debug settings remain as they were.

Top module: `dbg_ctl_reg`

## Requirements
- R1: While the synchronous active-low power-on reset `por_n` is low at a clock edge, the register returns to 00H and `halt_fetch`, `ack_send` and `core_rst` are 0 after that edge.
- R2: Register bit 7 is the halt bit and `halt_fetch` follows it. Writing bit 7 as 1 sets it. Writing it as 0 clears it when `flash_prot` is 0. The change is visible on the outputs after the write edge.
- R3: Bit 6 enables breakpoints. When `brk_seen` is 1 and bit 6 is 1 at an edge, bit 7 is 1 after that edge. This takes priority over a write of 0 to bit 7 in the same cycle.
- R4: When bit 6 is 0, a `brk_seen` pulse leaves the register and `halt_fetch` unchanged.
- R5: When `flash_prot` is 1, a write of 0 to bit 7 leaves it at 1, while the other bits of that write still take effect. A power-on reset still clears it.
- R6: Bit 5 enables the acknowledge. `ack_send` is 1 for exactly the one cycle after an edge where a breakpoint moved bit 7 from 0 to 1 while bit 5 was 1. A breakpoint while halted, or with bit 5 at 0, gives no pulse. `ack_char` carries the acknowledge byte, FFH by default.
- R7: Bits 6 and 5 read back as written. Bits 4:1 always read 0, whatever value is written to them. `cfg_rdata` shows the register at all times, with no read strobe.
- R8: Writing bit 0 as 1 when it is 0 sets bit 0 and asserts `core_rst` from the next cycle for exactly RST_CYCLES cycles. Bit 0 stays 1 for one further cycle after `core_rst` falls, and then reads 0.
- R9: A write of 0 to bit 0, or a write of 1 while bit 0 is already set, does not shorten or restart the sequence. The device reset leaves bits 7:5 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset |
| cfg_wr | input | 1 | Register write strobe from the debug link |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Current register contents |
| brk_seen | input | 1 | One-cycle pulse: breakpoint opcode decoded |
| flash_prot | input | 1 | Flash read protection active |
| halt_fetch | output | 1 | Stop instruction fetch in the core |
| ack_send | output | 1 | One-cycle request to transmit `ack_char` to the host |
| ack_char | output | 8 | Acknowledge byte value |
| core_rst | output | 1 | Device reset output (does not reset this block) |

## Verification
The bench uses the default parameters: RST_CYCLES = 16 and an acknowledge byte of FFH. The 16-cycle reset window is long enough for the bench to issue a second reset write and a write of 0 to bit 0 inside the window, and then count the exact length of `core_rst`. The bench sets the acknowledge byte to FFH and checks `ack_char` against that value. The vector table covers the interaction of breakpoints, writes and the protect input cycle by cycle. This includes a breakpoint and a clearing write arriving in the same cycle, and repeat breakpoints while the core is halted.

// File: rtl/dbg_ctl_pkg.sv
// Package dbg_ctl_pkg
// Holds the register bit positions and the type for the three debug mode
// bits, which the mode logic and the top module share.
// Assumes an 8-bit register with bits 4:1 unused.
package dbg_ctl_pkg;

    localparam int REG_W     = 8;
    localparam int POS_HALT  = 7;
    localparam int POS_BPEN  = 6;
    localparam int POS_ACKEN = 5;
    localparam int POS_RST   = 0;

    typedef struct packed {
        logic halt;
        logic bp_en;
        logic ack_en;
    } dbg_mode_t;

endpackage

// File: rtl/dbg_mode_ctl.sv
// Module dbg_mode_ctl
// Keeps the halt, breakpoint-enable and acknowledge-enable bits. It applies
// host writes, sets halt automatically on an enabled breakpoint, blocks the
// host from releasing halt while flash protection is on, and raises a
// one-cycle acknowledge request when a breakpoint causes the halt.
// Assumes brk is a one-cycle strobe and the reset is synchronous active-low.
module dbg_mode_ctl
    import dbg_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             brk,
    input  logic             prot,
    output dbg_mode_t        mode,
    output logic             ack_req
);

    dbg_mode_t mode_q;
    dbg_mode_t mode_d;
    logic      brk_take;
    logic      ack_q;

    // A breakpoint only acts when breakpoints are enabled
    assign brk_take = brk && mode_q.bp_en;

    // Next state of the three mode bits
    always_comb begin
        mode_d = mode_q;
        if (wr) begin
            mode_d.bp_en  = wdata[POS_BPEN];
            mode_d.ack_en = wdata[POS_ACKEN];
            if (wdata[POS_HALT])
                mode_d.halt = 1'b1;
            else if (!prot)
                mode_d.halt = 1'b0;
        end
        if (brk_take)
            mode_d.halt = 1'b1;
    end

    // Mode register with synchronous power-on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else
            mode_q <= mode_d;
    end

    // Acknowledge pulse on a breakpoint-caused halt entry
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else
            ack_q <= brk_take && !mode_q.halt && mode_q.ack_en;
    end

    assign mode    = mode_q;
    assign ack_req = ack_q;

    assert_brk_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && mode_q.bp_en) |=> mode_q.halt);

    assert_brk_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !mode_q.bp_en && !wr) |=> $stable(mode_q));

    assert_prot_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot && mode_q.halt) |=> mode_q.halt);

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> !ack_q);

    assert_ack_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> mode_q.halt);

endmodule

// File: rtl/dbg_rst_seq.sv
// Module dbg_rst_seq
// Runs the self-clearing device reset. A write of 1 while idle sets the
// request bit and starts a counter that holds core_rst for RST_CYCLES
// cycles. The request bit clears one cycle after core_rst drops.
// Assumes RST_CYCLES >= 2. Writes of 0, and writes while busy, are ignored.
module dbg_rst_seq #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wbit,
    output logic req_bit,
    output logic core_rst
);

    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    logic          req_q;
    logic          run_q;
    logic          done_q;
    logic [CW-1:0] cnt_q;
    logic          start;

    // A new sequence starts only from idle
    assign start = wr && wbit && !req_q;

    // Request bit: set on start, cleared the cycle after the window ends
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (start)
            req_q <= 1'b1;
        else if (done_q)
            req_q <= 1'b0;
    end

    // Window counter and core reset output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                run_q <= 1'b1;
                cnt_q <= '0;
            end else if (run_q) begin
                if (cnt_q == LAST) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign req_bit  = req_q;
    assign core_rst = run_q;

    assert_rst_under_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> req_q);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> !run_q && !$past(run_q));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != LAST) |=> run_q);

endmodule

// File: rtl/dbg_ctl_reg.sv
// Module dbg_ctl_reg
// Top of the debug control register. Combines the mode bits and the reset
// sequencer into an 8-bit readable register, and drives the halt,
// acknowledge and core-reset outputs. Only por_n resets this block.
// Assumes single-cycle writes and a one-cycle breakpoint strobe.
module dbg_ctl_reg
    import dbg_ctl_pkg::*;
#(
    parameter int         RST_CYCLES = 16,
    parameter logic [7:0] ACK_CHAR   = 8'hFF
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       brk_seen,
    input  logic       flash_prot,
    output logic       halt_fetch,
    output logic       ack_send,
    output logic [7:0] ack_char,
    output logic       core_rst
);

    dbg_mode_t mode;
    logic      req_bit;

    dbg_mode_ctl u_mode (
        .clk     (clk),
        .rst_n   (por_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .brk     (brk_seen),
        .prot    (flash_prot),
        .mode    (mode),
        .ack_req (ack_send)
    );

    dbg_rst_seq #(
        .RST_CYCLES (RST_CYCLES)
    ) u_rst (
        .clk      (clk),
        .rst_n    (por_n),
        .wr       (cfg_wr),
        .wbit     (cfg_wdata[POS_RST]),
        .req_bit  (req_bit),
        .core_rst (core_rst)
    );

    // Read view: unused bits are tied to 0
    always_comb begin
        cfg_rdata            = '0;
        cfg_rdata[POS_HALT]  = mode.halt;
        cfg_rdata[POS_BPEN]  = mode.bp_en;
        cfg_rdata[POS_ACKEN] = mode.ack_en;
        cfg_rdata[POS_RST]   = req_bit;
    end

    assign halt_fetch = mode.halt;
    assign ack_char   = ACK_CHAR;

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!por_n)
        cfg_rdata[4:1] == 4'b0000);

    assert_halt_out_R2: assert property (@(posedge clk) disable iff (!por_n)
        halt_fetch == cfg_rdata[POS_HALT]);

endmodule

// File: tb/dbg_ctl_reg_tb_top.sv
module dbg_ctl_reg_tb_top;

    localparam int         RST_CYCLES = 16;
    localparam logic [7:0] ACK_CHAR   = 8'hFF;

    logic       clk = 1'b0;
    logic       por_n;
    logic       cfg_wr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       brk_seen;
    logic       flash_prot;
    logic       halt_fetch;
    logic       ack_send;
    logic [7:0] ack_char;
    logic       core_rst;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    dbg_ctl_reg #(
        .RST_CYCLES (RST_CYCLES),
        .ACK_CHAR   (ACK_CHAR)
    ) dut_i (
        .clk        (clk),
        .por_n      (por_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .brk_seen   (brk_seen),
        .flash_prot (flash_prot),
        .halt_fetch (halt_fetch),
        .ack_send   (ack_send),
        .ack_char   (ack_char),
        .core_rst   (core_rst)
    );

    // Vector: {wr, wdata[7:0], brk, prot, exp_rd[7:0], exp_halt, exp_ack}
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // idle
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 brk, bp off
        {1'b1, 8'h7E, 1'b0, 1'b0, 8'h60, 1'b0, 1'b0}, // R7 reserved read 0
        {1'b0, 8'h00, 1'b1, 1'b0, 8'hE0, 1'b1, 1'b1}, // R3 R6 brk halts, ack
        {1'b0, 8'h00, 1'b1, 1'b0, 8'hE0, 1'b1, 1'b0}, // R6 brk while halted
        {1'b1, 8'h60, 1'b0, 1'b0, 8'h60, 1'b0, 1'b0}, // R2 release
        {1'b1, 8'h40, 1'b0, 1'b0, 8'h40, 1'b0, 1'b0}, // R7 ack off
        {1'b0, 8'h00, 1'b1, 1'b0, 8'hC0, 1'b1, 1'b0}, // R6 no ack when off
        {1'b1, 8'h40, 1'b1, 1'b0, 8'hC0, 1'b1, 1'b0}, // R3 brk beats write 0
        {1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R2 clear
        {1'b1, 8'h80, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0}, // R2 set by write
        {1'b1, 8'h00, 1'b0, 1'b1, 8'h80, 1'b1, 1'b0}, // R5 protected
        {1'b1, 8'h20, 1'b0, 1'b1, 8'hA0, 1'b1, 1'b0}, // R5 other bits apply
        {1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}  // R2 unprotected clear
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        int n;
        por_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; brk_seen = 1'b0; flash_prot = 1'b0;
        @(negedge clk);
        tick();
        // R1 power-on state
        chk("R1 rdata", cfg_rdata, 8'h00);
        chk("R1 outputs", {5'b0, halt_fetch, ack_send, core_rst}, 8'h00);
        por_n = 1'b1;
        tick();

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            cfg_wr     = VEC[i][20];
            cfg_wdata  = VEC[i][19:12];
            brk_seen   = VEC[i][11];
            flash_prot = VEC[i][10];
            tick();
            chk($sformatf("R2-vector %0d rdata", i), cfg_rdata, VEC[i][9:2]);
            chk($sformatf("R2 vector %0d halt", i), {7'b0, halt_fetch}, {7'b0, VEC[i][1]});
            chk($sformatf("R6 vector %0d ack", i), {7'b0, ack_send}, {7'b0, VEC[i][0]});
        end
        cfg_wr = 1'b0; brk_seen = 1'b0; flash_prot = 1'b0;
        chk("R6 ack_char", ack_char, 8'hFF);

        // R5 protected halt cleared only by power-on reset
        cfg_wr = 1'b1; cfg_wdata = 8'h80; flash_prot = 1'b1;
        tick();
        cfg_wr = 1'b1; cfg_wdata = 8'h00;
        tick();
        cfg_wr = 1'b0;
        chk("R5 held", cfg_rdata, 8'h80);
        por_n = 1'b0;
        tick();
        por_n = 1'b1;
        chk("R5 por clears", cfg_rdata, 8'h00);
        chk("R1 halt after por", {7'b0, halt_fetch}, 8'h00);
        flash_prot = 1'b0;
        tick();

        // R8 R9 device reset sequence
        cfg_wr = 1'b1; cfg_wdata = 8'hE1;
        tick();
        cfg_wr = 1'b0;
        chk("R8 core_rst asserted", {7'b0, core_rst}, 8'h01);
        n = 0;
        while (core_rst && n < 100) begin
            n++;
            chk("R8 bit0 held", {7'b0, cfg_rdata[0]}, 8'h01);
            cfg_wr = 1'b0;
            if (n == 3) begin cfg_wr = 1'b1; cfg_wdata = 8'hE1; end // R9 restart attempt
            if (n == 6) begin cfg_wr = 1'b1; cfg_wdata = 8'hE0; end // R9 write 0
            tick();
        end
        cfg_wr = 1'b0;
        chk("R8 window length", 8'(n), 8'(RST_CYCLES));
        chk("R8 bit0 one extra cycle", cfg_rdata, 8'hE1);
        tick();
        chk("R9 bits 7:5 kept, bit0 cleared", cfg_rdata, 8'hE0);
        chk("R8 core_rst idle", {7'b0, core_rst}, 8'h00);

        finish_run();
    end

endmodule